// File: doc/BRIEF.md
# SPI Flash Command Header Sequencer

This block produces the header of a serial NOR flash transaction inside a memory-mapped flash controller. A request carries an opcode, a flash address, a 3-byte or 4-byte addressing flag, a dummy-byte count and a chip-select number. The block selects that chip, then hands a byte-serial shifter the opcode, the address bytes and the dummy filler bytes one at a time over a valid/ready handshake. It then pulses a done strobe so the data phase can start, and it keeps the chip selected until the data phase reports its end.

A one-byte command control register on a simple register bus holds a mask for each address byte. Any address byte whose mask bit is set is left out of the header. With all mask bits set, an opcode that takes no address (an identification read, for example) uses the same read path as an ordinary array read. The register also stores one disable bit for each data byte lane and drives those bits out to the data-phase logic. Before the address bytes are sent, the address is clamped into the window that belongs to the selected chip.

Top module: `spi_cmd_seq`

## Requirements
- R1: The command control register is at byte offset 0x0C. A write there stores only wdata[7:0]. A read at 0x0C returns the stored byte zero-extended to 32 bits, and a read at any other offset returns 0. Reset value is 0.
- R2: Every transaction sends exactly one opcode byte, and it is the first byte handed to the shifter.
- R3: There are 4 candidate address bytes when req_addr4_i is 1 and 3 when it is 0. Byte i is address bits [8i+7:8i]. They are sent from the highest-numbered byte down to byte 0.
- R4: Register bit 4+i (i = 0..3) set means address byte i is skipped. With every candidate byte masked, the opcode is followed directly by the dummy bytes, or by the done pulse when the dummy count is 0.
- R5: The address that is sent equals (req_addr_i & (size-1)) + base, where base and size are the selected chip's fields in seg_base_i and seg_size_i (chip k at bits [32k+31:32k]), and size is a power of two.
- R6: After the address bytes, req_dummy_i filler bytes of value 0xFF are sent.
- R7: cs_n_o is active low and one-hot for the requested chip. It goes active the cycle after acceptance, which is one cycle before the opcode is offered. It stays active through the header and the data phase, and it returns to all ones on the clock edge where xfer_end_i is sampled high.
- R8: hdr_done_o is a single-cycle pulse in the cycle after the handshake of the last header byte. No header byte is offered while it is high.
- R9: req_ready_o is high only while the block is idle. A request presented while busy is ignored. A register write made during a transaction changes the byte mask from the next transaction on.
- R10: Register bits [3:0] are the data-lane disable bits (1 = disabled). They are driven on data_lane_dis_o.
- R11: While tx_valid_o is high and tx_ready_i is low, tx_valid_o stays high and tx_data_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| data_lane_dis_o | output | 4 | Data byte lane disable bits |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted (idle) |
| req_opcode_i | input | 8 | Command opcode |
| req_addr_i | input | ADDR_W | Flash address |
| req_addr4_i | input | 1 | 1 = 4 address bytes, 0 = 3 |
| req_dummy_i | input | DUM_W | Number of dummy bytes |
| req_cs_i | input | CS_W | Chip-select number |
| seg_base_i | input | CS_N*ADDR_W | Window base for each chip |
| seg_size_i | input | CS_N*ADDR_W | Window size for each chip (power of two) |
| tx_valid_o | output | 1 | Header byte valid |
| tx_data_o | output | 8 | Header byte |
| tx_ready_i | input | 1 | Shifter takes the byte |
| cs_n_o | output | CS_N | Chip selects, active low |
| hdr_done_o | output | 1 | Header complete pulse |
| xfer_end_i | input | 1 | Data phase finished, release chip select |

## Verification
On every cycle the assertions check the framing rules. A byte is offered only while a chip is selected, and that chip was already selected in the previous cycle. The selects are never more than one-hot. A stalled byte holds steady. The done strobe lasts a single cycle, never overlaps a byte offer, and the request side is never ready while a chip is selected. Only the bench scenarios can show that the byte stream itself is right: the opcode first, the clamped address bytes in descending order with masked bytes dropped in the 3-byte, 4-byte, all-masked and sparse-mask cases, the dummy filler count, and the rule that a mask written mid-transaction takes effect only from the next request.

// File: rtl/spi_cmd_seq_pkg.sv
package spi_cmd_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CSUP, ST_OPC, ST_ADDR, ST_DUMMY, ST_DATA
  } seq_state_e;
  localparam logic [7:0] CMD_CTRL_OFS = 8'h0C;
  localparam int unsigned ADDR_BYTES  = 4;
endpackage

// File: rtl/cmd_ctrl_reg.sv
module cmd_ctrl_reg #(
  parameter int unsigned  DW  = 32,
  parameter logic [7:0]   OFS = 8'h0C
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  output logic [DW-1:0] rdata_o,
  output logic [3:0]    addr_dis_o,
  output logic [3:0]    data_dis_o
);
  logic [7:0] ctrl_q;
  logic       hit;
  logic       unused_wdata;

  assign hit          = (addr_i == OFS);
  assign unused_wdata = ^wdata_i[DW-1:8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ctrl_q <= '0;
    else if (we_i && hit) ctrl_q <= wdata_i[7:0];
  end

  assign rdata_o    = hit ? {{(DW-8){1'b0}}, ctrl_q} : '0;
  assign addr_dis_o = ctrl_q[7:4];
  assign data_dis_o = ctrl_q[3:0];
endmodule

// File: rtl/seg_clamp.sv
module seg_clamp #(
  parameter int unsigned AW   = 32,
  parameter int unsigned CS_N = 2,
  localparam int unsigned CS_W = (CS_N > 1) ? $clog2(CS_N) : 1
) (
  input  logic [CS_W-1:0]    cs_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [CS_N*AW-1:0] base_i,
  input  logic [CS_N*AW-1:0] size_i,
  output logic [AW-1:0]      addr_o
);
  logic [AW-1:0] base_sel, size_sel;

  always_comb begin
    base_sel = '0;
    size_sel = '0;
    for (int k = 0; k < CS_N; k++) begin
      if (cs_i == CS_W'(k)) begin
        base_sel = base_i[k*AW +: AW];
        size_sel = size_i[k*AW +: AW];
      end
    end
  end

  // size is a power of two: mask keeps the in-window offset
  assign addr_o = (addr_i & (size_sel - AW'(1))) + base_sel;
endmodule

// File: rtl/msb_pick.sv
module msb_pick #(
  parameter int unsigned N = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (mask_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |mask_i;
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CS_N   = 2,
  parameter int unsigned DUM_W  = 4,
  parameter logic [7:0]  FILLER = 8'hFF,
  localparam int unsigned CS_W  = (CS_N > 1) ? $clog2(CS_N) : 1,
  localparam int unsigned BI_W  = $clog2(ADDR_BYTES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [7:0]           reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  input  logic                 reg_we_i,
  output logic [31:0]          reg_rdata_o,
  output logic [3:0]           data_lane_dis_o,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [7:0]           req_opcode_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic                 req_addr4_i,
  input  logic [DUM_W-1:0]     req_dummy_i,
  input  logic [CS_W-1:0]      req_cs_i,
  input  logic [CS_N*ADDR_W-1:0] seg_base_i,
  input  logic [CS_N*ADDR_W-1:0] seg_size_i,
  output logic                 tx_valid_o,
  output logic [7:0]           tx_data_o,
  input  logic                 tx_ready_i,
  output logic [CS_N-1:0]      cs_n_o,
  output logic                 hdr_done_o,
  input  logic                 xfer_end_i
);
  seq_state_e state_q, state_d;
  logic [7:0]            opc_q;
  logic [ADDR_W-1:0]     addr_q, addr_clamped;
  logic [ADDR_BYTES-1:0] pend_q, pend_init, pend_clr;
  logic [DUM_W-1:0]      dum_q;
  logic [CS_N-1:0]       cs_n_q, cs_sel;
  logic                  done_q;
  logic [3:0]            addr_dis;
  logic [BI_W-1:0]       byte_idx;
  logic                  pend_any;
  logic                  hs;
  logic                  unused_addr;

  cmd_ctrl_reg #(.DW(32), .OFS(CMD_CTRL_OFS)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .we_i       (reg_we_i),
    .rdata_o    (reg_rdata_o),
    .addr_dis_o (addr_dis),
    .data_dis_o (data_lane_dis_o)
  );

  seg_clamp #(.AW(ADDR_W), .CS_N(CS_N)) u_clamp (
    .cs_i   (req_cs_i),
    .addr_i (req_addr_i),
    .base_i (seg_base_i),
    .size_i (seg_size_i),
    .addr_o (addr_clamped)
  );

  msb_pick #(.N(ADDR_BYTES)) u_pick (
    .mask_i (pend_q),
    .any_o  (pend_any),
    .idx_o  (byte_idx)
  );

  always_comb begin
    for (int k = 0; k < CS_N; k++) cs_sel[k] = (req_cs_i == CS_W'(k));
  end

  // mask snapshot at accept: later register writes hit the next request
  assign pend_init   = ~addr_dis & (req_addr4_i ? 4'hF : 4'h7);
  assign pend_clr    = pend_q & ~(ADDR_BYTES'(1) << byte_idx);
  assign hs          = tx_valid_o & tx_ready_i;
  assign unused_addr = (ADDR_W > 32) ? ^addr_q : 1'b0;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid_i) state_d = ST_CSUP;
      ST_CSUP:  state_d = ST_OPC;
      ST_OPC:   if (hs) begin
                  if (pend_any)            state_d = ST_ADDR;
                  else if (dum_q != '0)    state_d = ST_DUMMY;
                  else                     state_d = ST_DATA;
                end
      ST_ADDR:  if (hs && pend_clr == '0) begin
                  state_d = (dum_q != '0) ? ST_DUMMY : ST_DATA;
                end
      ST_DUMMY: if (hs && dum_q == DUM_W'(1)) state_d = ST_DATA;
      ST_DATA:  if (xfer_end_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      opc_q   <= '0;
      addr_q  <= '0;
      pend_q  <= '0;
      dum_q   <= '0;
      cs_n_q  <= '1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_d == ST_DATA) && (state_q != ST_DATA);
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          opc_q  <= req_opcode_i;
          addr_q <= addr_clamped;
          pend_q <= pend_init;
          dum_q  <= req_dummy_i;
          cs_n_q <= ~cs_sel;
        end
        ST_ADDR:  if (hs) pend_q <= pend_clr;
        ST_DUMMY: if (hs) dum_q <= dum_q - DUM_W'(1);
        ST_DATA:  if (xfer_end_i) cs_n_q <= '1;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_OPC:   tx_data_o = opc_q;
      ST_ADDR:  tx_data_o = addr_q[{byte_idx, 3'b000} +: 8];
      ST_DUMMY: tx_data_o = FILLER;
      default:  tx_data_o = '0;
    endcase
  end

  assign tx_valid_o  = (state_q == ST_OPC) || (state_q == ST_ADDR) || (state_q == ST_DUMMY);
  assign req_ready_o = (state_q == ST_IDLE);
  assign cs_n_o      = cs_n_q;
  assign hdr_done_o  = done_q;
endmodule

// File: rtl/spi_cmd_seq_chk.sv
module spi_cmd_seq_chk #(
  parameter int unsigned CS_N = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_ready_o,
  input logic            tx_valid_o,
  input logic [7:0]      tx_data_o,
  input logic            tx_ready_i,
  input logic [CS_N-1:0] cs_n_o,
  input logic            hdr_done_o,
  input logic [31:0]     reg_rdata_o
);
  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[31:8] == '0); // R1
  AST_TX_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !(&cs_n_o)); // R7
  AST_CS_LEADS_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $past(!(&cs_n_o))); // R7
  AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_done_o |=> !hdr_done_o); // R8
  AST_DONE_NO_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_done_o |-> !tx_valid_o); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&cs_n_o) |-> !req_ready_o); // R9
  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o))); // R11
endmodule

bind spi_cmd_seq spi_cmd_seq_chk #(.CS_N(CS_N)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .tx_valid_o  (tx_valid_o),
  .tx_data_o   (tx_data_o),
  .tx_ready_i  (tx_ready_i),
  .cs_n_o      (cs_n_o),
  .hdr_done_o  (hdr_done_o),
  .reg_rdata_o (reg_rdata_o)
);

// File: tb/spi_cmd_seq_bench.sv
module spi_cmd_seq_bench;
  localparam int AW = 32, CSN = 2, DW = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0]  reg_addr_i = 8'h0C;
  logic [31:0] reg_wdata_i = '0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_rdata_o;
  logic [3:0]  data_lane_dis_o;
  logic        req_valid_i = 1'b0, req_ready_o;
  logic [7:0]  req_opcode_i = '0;
  logic [AW-1:0] req_addr_i = '0;
  logic        req_addr4_i = 1'b0;
  logic [DW-1:0] req_dummy_i = '0;
  logic        req_cs_i = 1'b0;
  logic [CSN*AW-1:0] seg_base_i, seg_size_i;
  logic        tx_valid_o, tx_ready_i = 1'b1;
  logic [7:0]  tx_data_o;
  logic [CSN-1:0] cs_n_o;
  logic        hdr_done_o, xfer_end_i = 1'b0;

  assign seg_base_i = {32'h0800_0000, 32'h0000_0000};
  assign seg_size_i = {32'h0010_0000, 32'h0100_0000};

  spi_cmd_seq u_spi_cmd_seq (.*);

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, done_seen = 0, cyc = 0;
  logic [7:0] exp_q[$];
  logic [3:0] model_dis = 4'h0;
  string cur_tag = "R2";
  bit stall_en = 1'b0, prev_valid = 1'b0, prev_cs_act = 1'b0, finished = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Monitor: drive ready at negedge, sample what the next posedge sees
  initial forever begin
    @(negedge clk_i);
    cyc++;
    tx_ready_i = !stall_en || (cyc % 3 == 0);
    #1;
    if (tx_valid_o && !prev_valid) chk(prev_cs_act, "R7 cs lead", prev_cs_act, 1);
    if (tx_valid_o && tx_ready_i) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 extra byte", tx_data_o, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(tx_data_o == e, cur_tag, tx_data_o, e);
      end
    end
    if (hdr_done_o) begin
      done_seen++;
      chk(exp_q.size() == 0, "R8 done early", exp_q.size(), 0);
    end
    prev_valid  = tx_valid_o;
    prev_cs_act = !(&cs_n_o);
  end

  task automatic reg_write(input logic [7:0] ofs, input logic [31:0] v);
    @(negedge clk_i);
    reg_addr_i = ofs; reg_wdata_i = v; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_addr_i = 8'h0C;
  endtask

  task automatic txn(input logic [7:0] opc, input logic [31:0] a, input bit a4,
                     input int dum, input bit cs, input string tag,
                     input bit mid_wr, input logic [31:0] mid_v, input bit busy_poke);
    logic [31:0] base, size, ca;
    int d0, nb;
    base = cs ? 32'h0800_0000 : 32'h0;
    size = cs ? 32'h0010_0000 : 32'h0100_0000;
    ca   = (a & (size - 1)) + base;
    nb   = a4 ? 4 : 3;
    cur_tag = tag;
    exp_q.push_back(opc);
    for (int i = nb - 1; i >= 0; i--) if (!model_dis[i]) exp_q.push_back(ca[8*i +: 8]);
    for (int i = 0; i < dum; i++) exp_q.push_back(8'hFF);
    d0 = done_seen;
    @(negedge clk_i);
    #2 chk(req_ready_o, "R9 idle ready", req_ready_o, 1);
    req_opcode_i = opc; req_addr_i = a; req_addr4_i = a4;
    req_dummy_i = DW'(dum); req_cs_i = cs; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    #2 chk(cs_n_o == ~(2'b01 << cs), "R7 cs select", cs_n_o, ~(2'b01 << cs));
    if (mid_wr) reg_write(8'h0C, mid_v);
    while (done_seen == d0) @(negedge clk_i);
    #2 chk(cs_n_o == ~(2'b01 << cs), "R7 cs hold", cs_n_o, ~(2'b01 << cs));
    if (busy_poke) begin
      req_opcode_i = 8'hEE; req_valid_i = 1'b1;
      repeat (4) begin
        @(negedge clk_i);
        #2 chk(!req_ready_o && !tx_valid_o, "R9 busy ignore", {req_ready_o, tx_valid_o}, 0);
      end
      req_valid_i = 1'b0;
    end
    @(negedge clk_i);
    xfer_end_i = 1'b1;
    @(negedge clk_i);
    xfer_end_i = 1'b0;
    #2 chk(&cs_n_o, "R7 cs release", cs_n_o, 2'b11);
    chk(req_ready_o, "R9 ready after", req_ready_o, 1);
    if (mid_wr) model_dis = mid_v[7:4];
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    chk(cs_n_o == 2'b11 && !tx_valid_o && !hdr_done_o, "R7 reset", {cs_n_o, tx_valid_o, hdr_done_o}, 4'b1100);
    chk(reg_rdata_o == 0, "R1 reset", reg_rdata_o, 0);
    rst_ni = 1'b1;
    // R1/R10 register
    reg_write(8'h0C, 32'hFFFF_FF0A);
    #1 chk(reg_rdata_o == 32'h0A, "R1 readback", reg_rdata_o, 32'h0A);
    chk(data_lane_dis_o == 4'hA, "R10 data lanes", data_lane_dis_o, 4'hA);
    reg_addr_i = 8'h10;
    #1 chk(reg_rdata_o == 0, "R1 other ofs", reg_rdata_o, 0);
    reg_addr_i = 8'h0C;
    // R3 3-byte and 4-byte, all enabled
    txn(8'h03, 32'h0012_3456, 1'b0, 0, 1'b0, "R3 3byte", 1'b0, 0, 1'b0);
    txn(8'h13, 32'h00AB_CDEF, 1'b1, 0, 1'b0, "R3 4byte", 1'b0, 0, 1'b0);
    // R5 clamp into chip 1 window, R6 one dummy
    txn(8'h0C, 32'h1234_5678, 1'b1, 1, 1'b1, "R5 clamp", 1'b0, 0, 1'b0);
    // R11 stalled shifter, R6 dummies
    stall_en = 1'b1;
    txn(8'h0B, 32'h00FE_DCBA, 1'b0, 2, 1'b0, "R11 stall R6", 1'b0, 0, 1'b1);
    stall_en = 1'b0;
    // R4 all address bytes masked
    reg_write(8'h0C, 32'h0000_00F0); model_dis = 4'hF;
    txn(8'h9F, 32'h00AA_BBCC, 1'b1, 0, 1'b0, "R4 no addr", 1'b0, 0, 1'b0);
    txn(8'h5A, 32'h00AA_BBCC, 1'b0, 3, 1'b1, "R4 R6 no addr dummy", 1'b0, 0, 1'b0);
    // R4 sparse mask: bytes 0 and 2 dropped; mid-transaction write (R9)
    reg_write(8'h0C, 32'h0000_0050); model_dis = 4'h5;
    txn(8'hEB, 32'hAABB_CCDD, 1'b1, 1, 1'b0, "R4 sparse R9 mid", 1'b1, 32'h0000_0000, 1'b0);
    txn(8'h03, 32'h0077_8899, 1'b0, 0, 1'b1, "R9 new mask", 1'b0, 0, 1'b0);
    chk(exp_q.size() == 0, "R2 stream end", exp_q.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule